// File: doc/BRIEF.md
# Software-Triggered Full-Duplex Serial Control Channel

This block moves a single control word to one or more attached devices over a three-line serial link. It receives a data input line as well, so each transfer also collects a reply word from the device. Software starts a transfer simply by writing a word into the output holding register. The word carries a payload and a group of line-select bits. While the payload is clocked out most significant bit first, the incoming line is clocked into a receive shift register. At the end of the transfer the received word becomes readable.

Two status flags report progress. The transmit-empty flag shows that the holding register has been handed to the shifter and can take the next word. The receive-full flag shows that a complete reply word is waiting. Each flag drives a shared, level-sensitive interrupt when its mask input is set. The serial bit rate comes from an external half-bit strobe. A write that arrives during a transfer is held, and it starts as soon as the current transfer ends.

Top module: `imc_serial_channel`

## Requirements
- R1: A one-cycle `wr_en` pulse loads `wr_data` into the holding register. On the second clock edge after the pulse, the transfer starts: `busy` rises and the selected enable lines assert.
- R2: The payload `wr_data[23:0]` is sent most significant bit first on `sdo`. `sdo` changes only when `sclk` falls (or on the load that starts a transfer), so it is stable at every rising edge of `sclk`.
- R3: `sclk` idles low. Each `bit_tick` pulse during a transfer toggles `sclk`, and 24 rising/falling pairs make one transfer. `sdi` is sampled on each rising edge of `sclk`, the first bit into bit 23. Once the transfer ends, `rd_data` shows the 24 sampled bits.
- R4: `tx_empty` is set on the clock edge where the holding register is copied into the shifter. This is the edge where the transfer starts, well before shifting ends.
- R5: `rx_full` is set on the clock edge that completes the 24th falling edge of `sclk`. On that same edge `busy` and all enable lines drop.
- R6: A write clears `tx_empty` on its clock edge. A one-cycle `rd_en` clears `rx_full`. When a clear and a set of the same flag fall on one edge, the clear of `tx_empty` wins and the set of `rx_full` wins.
- R7: `irq` is high exactly when (`tx_empty` and `mask_tx`) or (`rx_full` and `mask_rx`) holds. It is a level, not a pulse.
- R8: Select bits `wr_data[27:24]` map bit k to `en[k]` for the whole transfer. Any combination of the four lines may be active together, and all are low when idle.
- R9: A write during a transfer leaves `sdo` and `en` of the running transfer untouched. `tx_empty` stays low until the held word is copied, which happens on the edge right after the running transfer ends. `tx_empty` is set on that edge.
- R10: After reset, `sclk`, `sdo`, `en`, `busy`, both flags and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the output holding register |
| wr_data | input | 28 | [27:24] enable select, [23:0] payload |
| rd_en | input | 1 | Read strobe for the received word; clears rx_full |
| rd_data | output | 24 | Last completely received word |
| mask_tx | input | 1 | Lets tx_empty drive irq |
| mask_rx | input | 1 | Lets rx_full drive irq |
| bit_tick | input | 1 | Half-bit strobe from the serial clock generator |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| en | output | 4 | Device enable lines |
| busy | output | 1 | Transfer in progress |
| tx_empty | output | 1 | Holding register handed to the shifter |
| rx_full | output | 1 | Received word waiting |
| irq | output | 1 | Masked OR of the two flags |

## Verification
The hardest situation to reach is a second write landing in the middle of a running transfer. The checks must confirm that the running transfer keeps its payload and enable lines, that the held word starts exactly one clock after the 24th falling edge, and that `tx_empty` rises on that copy edge and not before. The bench reaches this by stepping `bit_tick` one half-bit at a time and inserting the second write after a chosen number of bits. It then counts edges through the handover. A table of words, select patterns, reply patterns and mask settings covers the plain transfers, and masks are toggled on an idle channel to probe the interrupt level.

// File: rtl/imc_pkg.sv
package imc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } shift_st_e;
endpackage

// File: rtl/imc_shift_engine.sv
module imc_shift_engine
    import imc_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [SEL_W-1:0]  load_sel,
    input  logic              tick,
    input  logic              sdi,
    output logic              busy,
    output logic              sclk,
    output logic              sdo,
    output logic [SEL_W-1:0]  en,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        shift_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [SEL_W-1:0]  en;
    } eng_t;

    eng_t q, d;
    logic done_d;

    always_comb begin
        d      = q;
        done_d = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (load) begin
                    d.st  = ST_LOW;
                    d.tx  = load_word;
                    d.en  = load_sel;
                    d.cnt = '0;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.st = ST_HIGH;
                    d.rx = {q.rx[WORD_W-2:0], sdi};
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.st   = ST_IDLE;
                        d.en   = '0;
                        done_d = 1'b1;
                    end else begin
                        d.st  = ST_LOW;
                        d.cnt = q.cnt + 1'b1;
                        d.tx  = {q.tx[WORD_W-2:0], 1'b0};
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, tx: '0, rx: '0, en: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign sclk    = (q.st == ST_HIGH);
    assign sdo     = busy ? q.tx[WORD_W-1] : 1'b0;
    assign en      = q.en;
    assign done    = done_d;
    assign rx_word = q.rx;

    // R2
    sdo_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdo));

    // R8
    en_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (q.en == '0));

    // R3
    bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);
endmodule

// File: rtl/imc_status.sv
module imc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic rd,
    input  logic copy,
    input  logic done,
    input  logic mask_tx,
    input  logic mask_rx,
    output logic tx_empty,
    output logic rx_full,
    output logic irq
);
    typedef struct packed {
        logic txe;
        logic rxf;
    } flag_t;

    flag_t q, d;

    always_comb begin
        d = q;
        if (wr)        d.txe = 1'b0;
        else if (copy) d.txe = 1'b1;
        if (done)      d.rxf = 1'b1;
        else if (rd)   d.rxf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_empty = q.txe;
    assign rx_full  = q.rxf;
    assign irq      = (q.txe & mask_tx) | (q.rxf & mask_rx);

    // R6
    rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !rx_full);
endmodule

// File: rtl/imc_serial_channel.sv
module imc_serial_channel #(
    parameter int WORD_W = 24,
    parameter int SEL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W+WORD_W-1:0] wr_data,
    input  logic                    rd_en,
    output logic [WORD_W-1:0]       rd_data,
    input  logic                    mask_tx,
    input  logic                    mask_rx,
    input  logic                    bit_tick,
    output logic                    sclk,
    output logic                    sdo,
    input  logic                    sdi,
    output logic [SEL_W-1:0]        en,
    output logic                    busy,
    output logic                    tx_empty,
    output logic                    rx_full,
    output logic                    irq
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SEL_W-1:0]  sel;
        logic              pend;
        logic [WORD_W-1:0] rx;
    } hold_t;

    hold_t q, d;
    logic copy, done;
    logic [WORD_W-1:0] rx_word;

    assign copy = q.pend & ~busy;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.word = wr_data[WORD_W-1:0];
            d.sel  = wr_data[SEL_W+WORD_W-1:WORD_W];
            d.pend = 1'b1;
        end else if (copy) begin
            d.pend = 1'b0;
        end
        if (done) d.rx = rx_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.rx;

    imc_shift_engine #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .load(copy), .load_word(q.word),
        .load_sel(q.sel), .tick(bit_tick), .sdi(sdi), .busy(busy),
        .sclk(sclk), .sdo(sdo), .en(en), .done(done), .rx_word(rx_word)
    );

    imc_status u_status (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .rd(rd_en), .copy(copy),
        .done(done), .mask_tx(mask_tx), .mask_rx(mask_rx),
        .tx_empty(tx_empty), .rx_full(rx_full), .irq(irq)
    );

    // R4
    copy_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy && !wr_en) |=> (tx_empty && busy));

    // R5
    done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx_full && !busy));

    // R6
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);

    // R7
    irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_empty && mask_tx) || (rx_full && mask_rx)) |-> irq);

    // R9
    held_word_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (busy && !tx_empty));
endmodule

// File: tb/tb_imc_serial_channel.sv
module tb_imc_serial_channel;
    localparam int W = 24;
    localparam int S = 4;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rd_en = 0, mask_tx = 0, mask_rx = 0, bit_tick = 0, sdi = 0;
    logic [S+W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic sclk, sdo, busy, tx_empty, rx_full, irq;
    logic [S-1:0] en;

    int checks = 0, errors = 0, cyc = 0;

    imc_serial_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .mask_tx(mask_tx), .mask_rx(mask_rx),
        .bit_tick(bit_tick), .sclk(sclk), .sdo(sdo), .sdi(sdi), .en(en),
        .busy(busy), .tx_empty(tx_empty), .rx_full(rx_full), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [S-1:0] sel, input logic [W-1:0] word);
        @(negedge clk); wr_en = 1; wr_data = {sel, word};
        @(negedge clk); wr_en = 0;
    endtask

    task automatic tick_once();
        @(negedge clk); bit_tick = 1;
        @(negedge clk); bit_tick = 0;
    endtask

    // shifts bits [first..last]; counts sdo mismatches at high sclk and sclk phase errors
    task automatic shift_bits(input logic [W-1:0] word, input logic [W-1:0] rx,
                              input int first, input int last, inout int bad);
        for (int i = first; i <= last; i++) begin
            sdi = rx[W-1-i];
            tick_once();
            if (sclk !== 1'b1 || sdo !== word[W-1-i]) bad++;
            tick_once();
            if (sclk !== 1'b0) bad++;
            if (i < W-1 && sdo !== word[W-2-i]) bad++;
        end
    endtask

    typedef struct packed {
        logic [S-1:0] sel;
        logic [W-1:0] word;
        logic [W-1:0] rx;
        logic         mtx;
        logic         mrx;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{4'b0001, 24'hA5C3F0, 24'h123456, 1'b1, 1'b1},
        '{4'b1010, 24'h800001, 24'hFFFFFF, 1'b0, 1'b1},
        '{4'b1111, 24'h000000, 24'h5A5A5A, 1'b1, 1'b0},
        '{4'b0110, 24'h7FFFFE, 24'h000001, 1'b0, 1'b0}
    };

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 sclk", sclk, 0); chk("R10 en", en, 0);
        chk("R10 busy/flags/irq", {busy, tx_empty, rx_full, irq, sdo}, 0);
        @(negedge clk); rst_n = 1;

        foreach (VECS[k]) begin
            mask_tx = VECS[k].mtx; mask_rx = VECS[k].mrx;
            do_write(VECS[k].sel, VECS[k].word);
            chk("R6 write clears empty", tx_empty, 0);
            chk("R1 not yet busy", busy, 0);
            @(negedge clk);
            chk("R1 busy after load", busy, 1);
            chk("R8 enables follow select", en, VECS[k].sel);
            chk("R4 empty set at copy", tx_empty, 1);
            chk("R2 first bit is MSB", sdo, VECS[k].word[W-1]);
            chk("R7 irq with empty", irq, VECS[k].mtx);
            bad = 0;
            shift_bits(VECS[k].word, VECS[k].rx, 0, W-2, bad);
            chk("R8 enables held mid transfer", en, VECS[k].sel);
            chk("R5 not full before last edge", rx_full, 0);
            shift_bits(VECS[k].word, VECS[k].rx, W-1, W-1, bad);
            chk("R2 R3 serial bit errors", bad, 0);
            chk("R5 full at end", rx_full, 1);
            chk("R5 idle at end", {busy, en, sclk}, 0);
            chk("R3 received word", rd_data, VECS[k].rx);
            chk("R7 irq both", irq, VECS[k].mtx | VECS[k].mrx);
            @(negedge clk); rd_en = 1;
            @(negedge clk); rd_en = 0;
            chk("R6 read clears full", rx_full, 0);
            chk("R7 irq after read", irq, VECS[k].mtx);
        end

        // R7 mask toggling while idle, tx_empty=1 rx_full=0
        mask_tx = 0; mask_rx = 1; @(negedge clk);
        chk("R7 masked empty gives no irq", irq, 0);
        mask_tx = 1; @(negedge clk);
        chk("R7 unmasked empty gives irq", irq, 1);

        // R9 write held during transfer
        mask_tx = 0; mask_rx = 0;
        do_write(4'b0011, 24'hC0FFEE);
        @(negedge clk);
        bad = 0;
        shift_bits(24'hC0FFEE, 24'h0F0F0F, 0, 4, bad);
        do_write(4'b1100, 24'h3A5A01);
        chk("R9 running enables kept", en, 4'b0011);
        chk("R9 empty low while held", tx_empty, 0);
        shift_bits(24'hC0FFEE, 24'h0F0F0F, 5, W-1, bad);
        chk("R9 first payload intact", bad, 0);
        chk("R9 idle gap, empty still low", {busy, tx_empty, en}, 0);
        chk("R3 first reply", rd_data, 24'h0F0F0F);
        @(negedge clk);
        chk("R9 held word started", {busy, en}, {1'b1, 4'b1100});
        chk("R9 empty set at copy", tx_empty, 1);
        chk("R9 held MSB out", sdo, 1'b0);
        bad = 0;
        shift_bits(24'h3A5A01, 24'hA00005, 0, W-1, bad);
        chk("R9 held payload", bad, 0);
        chk("R3 second reply", rd_data, 24'hA00005);

        // R6 done wins over read in same cycle
        do_write(4'b0001, 24'h000F00);
        @(negedge clk);
        bad = 0;
        shift_bits(24'h000F00, 24'h111111, 0, W-2, bad);
        sdi = 1'b1;
        @(negedge clk); bit_tick = 1;
        @(negedge clk); bit_tick = 0; rd_en = 1; bit_tick = 1;
        @(negedge clk); bit_tick = 0; rd_en = 0;
        chk("R6 set of full wins over read", rx_full, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule